// File: doc/BRIEF.md
# Modem Line Control and Status Unit

This unit holds the modem-control and modem-status registers of a serial port. It drives four control outputs (request-to-send, data-terminal-ready and two general outputs) from a host-written control byte. It watches four incoming status lines: clear-to-send, data-set-ready, ring and carrier detect.

Each incoming line passes through a synchronizer. The unit then latches a sticky change flag per line. The ring line is flagged only when it drops. All four flags clear when the host reads the status byte. When the host has enabled modem-status interrupts, any set flag raises an interrupt request.

A loop flag in the control byte turns on a self-test mode. In this mode the status lines are taken from the control bits instead of the pins, and the request-to-send and data-terminal-ready pins are forced inactive. The loop flag is exported so that the serial data path can return transmitted characters to its receiver.

Top module: `modem_line_ctrl`

## Requirements
- R1: After synchronous reset the control byte reads 0x08. out2_out is 1, and rts_out, dtr_out, out1_out, loop_mode and irq are 0. The four change flags stay clear even though the synchronized input levels settle after reset.
- R2: A write with sel_ctl stores wr_data bits 4:0. A control read returns those five bits with bits 7:5 read as zero.
- R3: Outside loopback, dtr_out follows control bit 0, rts_out bit 1, out1_out bit 2 and out2_out bit 3, starting on the clock edge that stores the write.
- R4: In the status byte, bit 4 is clear-to-send, bit 5 data-set-ready, bit 6 ring and bit 7 carrier detect. Outside loopback these bits follow the pins after SYNC_STAGES clocks.
- R5: Status bit 0 latches any change of clear-to-send, bit 1 any change of data-set-ready, and bit 3 any change of carrier detect, in either direction.
- R6: Status bit 2 latches only a 1-to-0 change of the ring level; a rising ring level leaves it clear.
- R7: A status read returns the current flags on rd_data in the next cycle and clears all four flags.
- R8: Control bit 4 sets loop_mode. While it is set, the status levels are clear-to-send = bit 1, data-set-ready = bit 0, ring = bit 2 and carrier = bit 3 of the control byte, and the external status pins have no effect.
- R9: While loop_mode is 1, rts_out and dtr_out are 0; out1_out and out2_out keep following control bits 2 and 3.
- R10: irq is 1 exactly when stat_irq_en was 1 and at least one change flag is set, registered one cycle after either.
- R11: A write with sel_sts (and not sel_ctl) changes neither the control byte nor the change flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_ctl | input | 1 | Selects the control register |
| sel_sts | input | 1 | Selects the status register |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data, 0 when no read |
| stat_irq_en | input | 1 | Modem-status interrupt enable |
| cts_in | input | 1 | Clear-to-send line (1 = asserted) |
| dsr_in | input | 1 | Data-set-ready line |
| ri_in | input | 1 | Ring line |
| dcd_in | input | 1 | Carrier-detect line |
| rts_out | output | 1 | Request-to-send output |
| dtr_out | output | 1 | Data-terminal-ready output |
| out1_out | output | 1 | General output 1 |
| out2_out | output | 1 | General output 2 |
| loop_mode | output | 1 | Loopback flag for the data path |
| irq | output | 1 | Modem-status interrupt request |

## Verification
The bench first holds several status pins high through reset. A design without the settle window would then report false change flags right after reset.

It raises and drops the ring line separately. A design that flags both edges, or only the rising one, would show status bit 2 at the wrong time.

It enters loopback with control bits that differ from the pin levels, then moves the pins while looped. A wrong remap, or a leak from the pins, would corrupt the status nibble, and a design that keeps driving the pins in this mode would leave rts_out or dtr_out high.

Random sequences of control writes, pin changes, enable toggles and status reads then catch flags that fail to clear on a read, or an irq that does not track the enable.

// File: rtl/modem_line_pkg.sv
package modem_line_pkg;
  localparam int CTL_W    = 5;
  localparam int LN_W     = 4;
  // control byte bit positions
  localparam int CTL_DTR  = 0;
  localparam int CTL_RTS  = 1;
  localparam int CTL_OUT1 = 2;
  localparam int CTL_OUT2 = 3;
  localparam int CTL_LOOP = 4;
  // line vector positions (status nibble order)
  localparam int LN_CTS   = 0;
  localparam int LN_DSR   = 1;
  localparam int LN_RI    = 2;
  localparam int LN_DCD   = 3;
  localparam logic [CTL_W-1:0] CTL_RESET = 5'h08;

  typedef logic [LN_W-1:0]  lines_t;
  typedef logic [CTL_W-1:0] ctl_t;

  // status levels seen while looped back
  function automatic lines_t loop_map(input ctl_t c);
    lines_t l;
    l[LN_CTS] = c[CTL_RTS];
    l[LN_DSR] = c[CTL_DTR];
    l[LN_RI]  = c[CTL_OUT1];
    l[LN_DCD] = c[CTL_OUT2];
    return l;
  endfunction
endpackage

// File: rtl/modem_line_sync.sv
module modem_line_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= '0;
        else     stg[i] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= '0;
        else     stg[i] <= stg[i-1];
      end
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/modem_line_delta.sv
module modem_line_delta
  import modem_line_pkg::*;
#(
  parameter int SETTLE = 3
) (
  input  logic   clk,
  input  logic   rst,
  input  lines_t lev,
  input  logic   clr,
  output lines_t delta_q,
  output lines_t delta_nxt,
  output lines_t prev_q
);
  localparam int CW = $clog2(SETTLE + 1);

  logic [CW-1:0] settle_q;
  lines_t        chg;

  for (genvar i = 0; i < LN_W; i++) begin : g_edge
    if (i == LN_RI) begin : g_fall
      assign chg[i] = (settle_q == '0) && prev_q[i] && !lev[i];
    end else begin : g_any
      assign chg[i] = (settle_q == '0) && (prev_q[i] != lev[i]);
    end
  end

  always_comb delta_nxt = (clr ? '0 : delta_q) | chg;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q   <= '0;
      delta_q  <= '0;
      settle_q <= CW'(SETTLE);
    end else begin
      prev_q  <= lev;
      delta_q <= delta_nxt;
      if (settle_q != '0) settle_q <= settle_q - 1'b1;
    end
  end
endmodule

// File: rtl/modem_line_ctrl.sv
module modem_line_ctrl
  import modem_line_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sel_ctl,
  input  logic       sel_sts,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       stat_irq_en,
  input  logic       cts_in,
  input  logic       dsr_in,
  input  logic       ri_in,
  input  logic       dcd_in,
  output logic       rts_out,
  output logic       dtr_out,
  output logic       out1_out,
  output logic       out2_out,
  output logic       loop_mode,
  output logic       irq
);
  localparam int SETTLE = SYNC_STAGES + 1;

  ctl_t   ctl_q, ctl_nxt;
  lines_t ext_raw, ext_sync, lev_eff;
  lines_t delta_q, delta_nxt, prev_q;
  logic   wr_ctl, rd_ctl, rd_sts;
  logic   unused_hi;

  assign unused_hi = ^wr_data[7:CTL_W];

  assign ext_raw[LN_CTS] = cts_in;
  assign ext_raw[LN_DSR] = dsr_in;
  assign ext_raw[LN_RI]  = ri_in;
  assign ext_raw[LN_DCD] = dcd_in;

  modem_line_sync #(.WIDTH(LN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (ext_raw),
    .dout(ext_sync)
  );

  assign wr_ctl = wr_en && sel_ctl && !sel_sts;
  assign rd_sts = rd_en && sel_sts;
  assign rd_ctl = rd_en && sel_ctl && !sel_sts;

  assign ctl_nxt = wr_ctl ? wr_data[CTL_W-1:0] : ctl_q;
  assign lev_eff = ctl_q[CTL_LOOP] ? loop_map(ctl_q) : ext_sync;

  modem_line_delta #(.SETTLE(SETTLE)) u_delta (
    .clk      (clk),
    .rst      (rst),
    .lev      (lev_eff),
    .clr      (rd_sts),
    .delta_q  (delta_q),
    .delta_nxt(delta_nxt),
    .prev_q   (prev_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q     <= CTL_RESET;
      dtr_out   <= CTL_RESET[CTL_DTR];
      rts_out   <= CTL_RESET[CTL_RTS];
      out1_out  <= CTL_RESET[CTL_OUT1];
      out2_out  <= CTL_RESET[CTL_OUT2];
      loop_mode <= CTL_RESET[CTL_LOOP];
      irq       <= 1'b0;
      rd_data   <= 8'h00;
    end else begin
      ctl_q     <= ctl_nxt;
      dtr_out   <= ctl_nxt[CTL_DTR] && !ctl_nxt[CTL_LOOP];
      rts_out   <= ctl_nxt[CTL_RTS] && !ctl_nxt[CTL_LOOP];
      out1_out  <= ctl_nxt[CTL_OUT1];
      out2_out  <= ctl_nxt[CTL_OUT2];
      loop_mode <= ctl_nxt[CTL_LOOP];
      irq       <= stat_irq_en && (delta_nxt != '0);
      if (rd_sts)      rd_data <= {lev_eff, delta_q};
      else if (rd_ctl) rd_data <= {3'b000, ctl_q};
      else             rd_data <= 8'h00;
    end
  end
endmodule

// File: rtl/modem_line_ctrl_chk.sv
module modem_line_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       rd_en,
  input logic       sel_ctl,
  input logic       sel_sts,
  input logic [7:0] rd_data,
  input logic       rts_out,
  input logic       dtr_out,
  input logic       loop_mode,
  input logic       irq,
  input logic       irq_en,
  input logic [3:0] delta,
  input logic [3:0] lev,
  input logic [3:0] prev
);
  // R2: control reads return zero in bits 7:5
  p_ctl_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel_ctl && !sel_sts) |=> (rd_data[7:5] == 3'b000));

  // R6: ring flag rises only after a 1-to-0 ring level
  p_ri_trailing_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(delta[2]) |-> ($past(prev[2]) && !$past(lev[2])));

  // R7: status read returns the flags held before the read
  p_read_flags_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel_sts) |=> (rd_data[3:0] == $past(delta)));

  // R9: looped back, handshake outputs are inactive
  p_loop_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    loop_mode |-> (!rts_out && !dtr_out));

  // R10: a request needs the enable in the previous cycle
  p_irq_enable_r10: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(irq_en));

  // R10: request tracks the flags and enable
  p_irq_flags_r10: assert property (@(posedge clk) disable iff (rst)
    irq |-> (delta != 4'h0));
endmodule

bind modem_line_ctrl modem_line_ctrl_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .rd_en    (rd_en),
  .sel_ctl  (sel_ctl),
  .sel_sts  (sel_sts),
  .rd_data  (rd_data),
  .rts_out  (rts_out),
  .dtr_out  (dtr_out),
  .loop_mode(loop_mode),
  .irq      (irq),
  .irq_en   (stat_irq_en),
  .delta    (delta_q),
  .lev      (lev_eff),
  .prev     (prev_q)
);

// File: tb/modem_line_ctrl_test.sv
module modem_line_ctrl_test;
  localparam int SYNC = 2;
  localparam int WAITC = SYNC + 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel_ctl = 1'b0, sel_sts = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic stat_irq_en = 1'b0;
  logic [3:0] ext = 4'b0000;
  logic rts_out, dtr_out, out1_out, out2_out, loop_mode, irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench model
  logic [4:0] m_ctl;
  logic [3:0] m_lev, m_delta;
  logic       m_en;

  always #2 clk = ~clk;

  modem_line_ctrl #(.SYNC_STAGES(SYNC)) uut (
    .clk(clk), .rst(rst), .sel_ctl(sel_ctl), .sel_sts(sel_sts),
    .wr_en(wr_en), .rd_en(rd_en), .wr_data(wr_data), .rd_data(rd_data),
    .stat_irq_en(stat_irq_en),
    .cts_in(ext[0]), .dsr_in(ext[1]), .ri_in(ext[2]), .dcd_in(ext[3]),
    .rts_out(rts_out), .dtr_out(dtr_out), .out1_out(out1_out),
    .out2_out(out2_out), .loop_mode(loop_mode), .irq(irq)
  );

  function automatic logic [3:0] lev_of(input logic [4:0] c, input logic [3:0] e);
    return c[4] ? {c[3], c[2], c[0], c[1]} : e;
  endfunction

  function automatic logic [3:0] chg_of(input logic [3:0] o, input logic [3:0] n);
    logic [3:0] d;
    d = o ^ n;
    d[2] = o[2] & ~n[2];
    return d;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    logic [3:0] nl;
    nl = lev_of(m_ctl, ext);
    m_delta = m_delta | chg_of(m_lev, nl);
    m_lev = nl;
  endtask

  task automatic settle();
    repeat (WAITC) @(negedge clk);
  endtask

  task automatic chk_pins(input string tag);
    check({tag, " pins"}, {dtr_out, rts_out, out1_out, out2_out, loop_mode},
          {m_ctl[0] & ~m_ctl[4], m_ctl[1] & ~m_ctl[4], m_ctl[2], m_ctl[3], m_ctl[4]});
    check({tag, " irq R10"}, {31'd0, irq}, {31'd0, m_en & (m_delta != 4'h0)});
  endtask

  task automatic wr_reg(input bit to_sts, input logic [7:0] v);
    sel_ctl = !to_sts; sel_sts = to_sts; wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0; sel_ctl = 1'b0; sel_sts = 1'b0;
    if (!to_sts) m_ctl = v[4:0];
    model_step();
    settle();
  endtask

  task automatic set_ext(input logic [3:0] v);
    ext = v;
    model_step();
    settle();
  endtask

  task automatic set_en(input logic b);
    stat_irq_en = b;
    m_en = b;
    settle();
  endtask

  task automatic rd_sts(input string tag);
    sel_sts = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; sel_sts = 1'b0;
    check({tag, " status R7"}, {24'd0, rd_data}, {24'd0, m_lev, m_delta});
    m_delta = 4'h0;
    settle();
  endtask

  task automatic rd_ctl(input string tag);
    sel_ctl = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; sel_ctl = 1'b0;
    check({tag, " ctl R2"}, {24'd0, rd_data}, {27'd0, m_ctl});
    settle();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4099));
    ext = 4'b1011;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    m_ctl = 5'h08; m_lev = 4'b1011; m_delta = 4'h0; m_en = 1'b0;
    // R1: reset pin state
    check("R1 reset pins", {dtr_out, rts_out, out1_out, out2_out, loop_mode, irq},
          6'b000100);
    check("R1 reset rd_data", {24'd0, rd_data}, 32'd0);
    settle();
    rd_sts("R1 no spurious flags R4");
    rd_ctl("R1 reset ctl");

    wr_reg(1'b0, 8'hE7);                 // R2 upper bits dropped, R3 pins
    rd_ctl("R2 write");
    chk_pins("R3 normal");

    set_ext(4'b1010);                    // R5 cts falls
    rd_sts("R5 cts");
    set_ext(4'b1110);                    // R6 ring rises: no flag
    rd_sts("R6 ring rise");
    set_ext(4'b1010);                    // R6 ring falls: flag
    rd_sts("R6 ring fall");
    set_ext(4'b1011);                    // R5 cts rises
    set_ext(4'b1001);                    // R5 dsr falls
    set_ext(4'b0001);                    // R5 dcd falls
    rd_sts("R5 multi");

    set_en(1'b1);
    set_ext(4'b1001);
    chk_pins("R10 raised");
    rd_sts("R10 clear");
    chk_pins("R10 dropped");

    wr_reg(1'b1, 8'hFF);                 // R11 status write ignored
    rd_sts("R11 sts");
    rd_ctl("R11 ctl");

    wr_reg(1'b0, 8'h1A);                 // R8 loop on: rts+out2
    chk_pins("R9 loop");
    rd_sts("R8 loop levels");
    set_ext(4'b0110);                    // R8 pins ignored while looped
    rd_sts("R8 pins ignored");
    wr_reg(1'b0, 8'h17);
    chk_pins("R9 loop out1");
    rd_sts("R8 remap");
    wr_reg(1'b0, 8'h03);                 // leave loop
    rd_sts("R8 exit");
    chk_pins("R3 after loop");

    for (int i = 0; i < 300; i++) begin
      int op;
      op = $urandom_range(0, 5);
      case (op)
        0: wr_reg(1'b0, 8'($urandom));
        1: set_ext(4'($urandom));
        2: rd_sts("R5 random");
        3: rd_ctl("R2 random");
        4: set_en(1'($urandom));
        default: wr_reg(1'b1, 8'($urandom));
      endcase
      chk_pins("R3 random");
    end
    rd_sts("R7 final");
    finish_run();
  end
endmodule